// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block models the read side of a mask-programmed ROM that can present its contents as 16-bit words or as 8-bit bytes. The width-select input chooses the view. In word mode the word address picks one stored word, and all 16 bits are driven. One of those bits leaves on a shared pin. In byte mode that same shared pin becomes an input and acts as the least significant bit of a byte address. The selected byte then appears on the low eight data bits.

Tri-state pins are represented as a data vector plus a per-bit drive-enable vector. The shared pin has its own value, drive flag and input. Chip enable is active low. Output enable has a build-time option: active low, active high, or ignored. The array is small and parameterised. It is initialised by a fill function of the word index and a seed parameter. Each output is registered, and the read latency is two clock edges. This allows the array to map onto block RAM.

Top module: `rom_dw_top`

## Requirements
- R1: With `wide_i`=1 and the port enabled, `data_o` carries bits 14..0 of the stored word, `pin15_o` carries bit 15, `drive_o` is all ones and `pin15_oe_o` is 1. `pin15_i` has no effect in this mode.
- R2: With `wide_i`=0 and the port enabled, the byte address is {`addr_i`, `pin15_i`}. `pin15_i`=0 selects bits 7..0 of the word and `pin15_i`=1 selects bits 15..8. The selected byte always appears on `data_o[7:0]`, with `drive_o[7:0]` all ones.
- R3: With `wide_i`=0, `drive_o[14:8]` is 0 and `pin15_oe_o` is 0.
- R4: With `ce_n_i`=1, no bit is driven, whatever the value of `oe_i`.
- R5: With `OE_OPT`=OE_ACT_LOW and `ce_n_i`=0, the port is enabled exactly when `oe_i`=0.
- R6: With `OE_OPT`=OE_ACT_HIGH and `ce_n_i`=0, the port is enabled exactly when `oe_i`=1.
- R7: With `OE_OPT`=OE_IGNORE, the port is enabled whenever `ce_n_i`=0, and `oe_i` has no effect.
- R8: Every bit whose drive flag is 0 reads as 0. This applies to `data_o` and to `pin15_o`.
- R9: While `rst` is high, and for the first clock edge after it falls, no bit is driven.
- R10: Outputs reflect the inputs sampled two rising edges earlier. A change in the inputs leaves the outputs unchanged after one edge.
- R11: The word index is `addr_i` modulo 2^`DEPTH_LOG2`, so address bits above that width are ignored. The word at index i is (i*0x9E37 + `FILL_SEED`) mod 2^16, with the default `FILL_SEED`=0x5A3C and `DEPTH_LOG2`=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address; in byte mode, the upper part of the byte address |
| pin15_i | input | 1 | Shared pin input value; byte-select LSB in byte mode |
| wide_i | input | 1 | 1 = word mode, 0 = byte mode |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_i | input | 1 | Output enable; polarity set by OE_OPT |
| data_o | output | DATA_W-1 | Data bits 14..0 |
| drive_o | output | DATA_W-1 | Per-bit drive enable for data_o |
| pin15_o | output | 1 | Shared pin output value (data bit 15) |
| pin15_oe_o | output | 1 | Shared pin drive enable |

## Verification
A stale or wrongly decoded enable register would show up two edges later. It would appear as drive flags that disagree with the chip-enable and output-enable combination applied at that time. A wrong width or byte-select register would show up within the same two edges. The symptoms would be upper bits driven in byte mode, the shared pin driven as an output when it should be an input, or the wrong half of the word on the low byte. Each pattern is therefore checked on the second edge after it is applied, on three builds, one for each output-enable option. A one-edge check separately confirms that the pipeline has no short path.

// File: rtl/rom_dw_pkg.sv
`timescale 1ns/1ps
package rom_dw_pkg;

  typedef enum logic [1:0] {
    OE_ACT_LOW  = 2'd0,
    OE_ACT_HIGH = 2'd1,
    OE_IGNORE   = 2'd2
  } oe_opt_e;

  typedef struct packed {
    logic en;
    logic wide;
    logic lsb;
  } rd_ctl_t;

  function automatic logic [15:0] fill_word(input int unsigned idx, input logic [15:0] seed);
    logic [31:0] acc;
    acc = idx * 32'h0000_9E37 + {16'h0, seed};
    return acc[15:0];
  endfunction

endpackage

// File: rtl/rom_dw_enable.sv
`timescale 1ns/1ps
module rom_dw_enable
  import rom_dw_pkg::*;
#(
  parameter oe_opt_e OE_OPT = OE_ACT_LOW
) (
  input  logic ce_n,
  input  logic oe,
  output logic en
);

  always_comb begin
    unique case (OE_OPT)
      OE_ACT_LOW:  en = ~ce_n & ~oe;
      OE_ACT_HIGH: en = ~ce_n &  oe;
      default:     en = ~ce_n;
    endcase
  end

endmodule

// File: rtl/rom_dw_array.sv
`timescale 1ns/1ps
module rom_dw_array
  import rom_dw_pkg::*;
#(
  parameter int          DEPTH_LOG2 = 8,
  parameter int          DATA_W     = 16,
  parameter logic [15:0] FILL_SEED  = 16'h5A3C
) (
  input  logic                  clk,
  input  logic [DEPTH_LOG2-1:0] idx,
  output logic [DATA_W-1:0]     q
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(fill_word(i, FILL_SEED));
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[idx];
  end

endmodule

// File: rtl/rom_dw_lane.sv
`timescale 1ns/1ps
module rom_dw_lane
  import rom_dw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_ctl_t           ctl,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-2:0] data_o,
  output logic [DATA_W-2:0] drive_o,
  output logic              pin15_o,
  output logic              pin15_oe_o
);

  localparam int HALF = DATA_W / 2;
  localparam int LOW_W = DATA_W - 1;

  logic [LOW_W-1:0] nxt_d;
  logic [LOW_W-1:0] nxt_drv;

  for (genvar b = 0; b < LOW_W; b++) begin : g_bit
    if (b < HALF) begin : g_low
      assign nxt_drv[b] = ctl.en;
      assign nxt_d[b]   = ctl.en & (ctl.wide ? word[b] : (ctl.lsb ? word[b+HALF] : word[b]));
    end else begin : g_high
      assign nxt_drv[b] = ctl.en & ctl.wide;
      assign nxt_d[b]   = ctl.en & ctl.wide & word[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o     <= '0;
      drive_o    <= '0;
      pin15_o    <= 1'b0;
      pin15_oe_o <= 1'b0;
    end else begin
      data_o     <= nxt_d;
      drive_o    <= nxt_drv;
      pin15_o    <= ctl.en & ctl.wide & word[DATA_W-1];
      pin15_oe_o <= ctl.en & ctl.wide;
    end
  end

endmodule

// File: rtl/rom_dw_top.sv
`timescale 1ns/1ps
module rom_dw_top
  import rom_dw_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          DATA_W     = 16,
  parameter int          DEPTH_LOG2 = 8,
  parameter logic [15:0] FILL_SEED  = 16'h5A3C,
  parameter oe_opt_e     OE_OPT     = OE_ACT_LOW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pin15_i,
  input  logic              wide_i,
  input  logic              ce_n_i,
  input  logic              oe_i,
  output logic [DATA_W-2:0] data_o,
  output logic [DATA_W-2:0] drive_o,
  output logic              pin15_o,
  output logic              pin15_oe_o
);

  logic                  en_comb;
  logic [DEPTH_LOG2-1:0] word_idx;
  logic [DATA_W-1:0]     word_q;
  rd_ctl_t               ctl_q;

  assign word_idx = addr_i[DEPTH_LOG2-1:0];

  if (DEPTH_LOG2 < ADDR_W) begin : g_hi_addr
    logic unused_hi_addr;
    assign unused_hi_addr = ^addr_i[ADDR_W-1:DEPTH_LOG2];
  end

  rom_dw_enable #(.OE_OPT(OE_OPT)) u_en (
    .ce_n (ce_n_i),
    .oe   (oe_i),
    .en   (en_comb)
  );

  rom_dw_array #(
    .DEPTH_LOG2 (DEPTH_LOG2),
    .DATA_W     (DATA_W),
    .FILL_SEED  (FILL_SEED)
  ) u_array (
    .clk (clk),
    .idx (word_idx),
    .q   (word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      ctl_q.en   <= en_comb;
      ctl_q.wide <= wide_i;
      ctl_q.lsb  <= pin15_i;
    end
  end

  rom_dw_lane #(.DATA_W(DATA_W)) u_lane (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl_q),
    .word       (word_q),
    .data_o     (data_o),
    .drive_o    (drive_o),
    .pin15_o    (pin15_o),
    .pin15_oe_o (pin15_oe_o)
  );

endmodule

// File: rtl/rom_dw_chk.sv
`timescale 1ns/1ps
module rom_dw_chk
  import rom_dw_pkg::*;
#(
  parameter int      DATA_W = 16,
  parameter oe_opt_e OE_OPT = OE_ACT_LOW
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_i,
  input logic              ce_n_i,
  input logic              oe_i,
  input logic [DATA_W-2:0] data_o,
  input logic [DATA_W-2:0] drive_o,
  input logic              pin15_o,
  input logic              pin15_oe_o
);

  localparam int HALF = DATA_W / 2;

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    since_rst < 2'd2 |-> (drive_o == '0 && !pin15_oe_o)); // R9

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && $past(ce_n_i, 2)) |-> (drive_o == '0 && !pin15_oe_o)); // R4

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && !$past(wide_i, 2)) |-> (drive_o[DATA_W-2:HALF] == '0 && !pin15_oe_o)); // R3

  AST_WORD_PIN_OUT: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && $past(wide_i, 2) && drive_o[0]) |-> (pin15_oe_o && drive_o == '1)); // R1

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((data_o & ~drive_o) == '0) && (pin15_oe_o || !pin15_o)); // R8

  AST_OE_ACT_LOW: assert property (@(posedge clk) disable iff (rst)
    (OE_OPT == OE_ACT_LOW && since_rst == 2'd2 && !$past(ce_n_i, 2)) |-> (drive_o[0] == !$past(oe_i, 2))); // R5

  AST_OE_ACT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (OE_OPT == OE_ACT_HIGH && since_rst == 2'd2 && !$past(ce_n_i, 2)) |-> (drive_o[0] == $past(oe_i, 2))); // R6

  AST_OE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (OE_OPT == OE_IGNORE && since_rst == 2'd2 && !$past(ce_n_i, 2)) |-> drive_o[0]); // R7

endmodule

bind rom_dw_top rom_dw_chk #(.DATA_W(DATA_W), .OE_OPT(OE_OPT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wide_i     (wide_i),
  .ce_n_i     (ce_n_i),
  .oe_i       (oe_i),
  .data_o     (data_o),
  .drive_o    (drive_o),
  .pin15_o    (pin15_o),
  .pin15_oe_o (pin15_oe_o)
);

// File: tb/tb_rom_dw_top.sv
`timescale 1ns/1ps
module tb_rom_dw_top;
  import rom_dw_pkg::*;

  localparam int          AW   = 20;
  localparam int          DLOG = 8;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic p15i = 1'b0, wide = 1'b1, ce_n = 1'b0, oe = 1'b0;

  logic [14:0] dat [3];
  logic [14:0] drv [3];
  logic        p15o [3];
  logic        p15oe [3];

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rom_dw_top #(.OE_OPT(OE_ACT_LOW)) dut (
    .clk(clk), .rst(rst), .addr_i(addr), .pin15_i(p15i), .wide_i(wide),
    .ce_n_i(ce_n), .oe_i(oe), .data_o(dat[0]), .drive_o(drv[0]),
    .pin15_o(p15o[0]), .pin15_oe_o(p15oe[0]));

  rom_dw_top #(.OE_OPT(OE_ACT_HIGH)) dut_hi (
    .clk(clk), .rst(rst), .addr_i(addr), .pin15_i(p15i), .wide_i(wide),
    .ce_n_i(ce_n), .oe_i(oe), .data_o(dat[1]), .drive_o(drv[1]),
    .pin15_o(p15o[1]), .pin15_oe_o(p15oe[1]));

  rom_dw_top #(.OE_OPT(OE_IGNORE)) dut_x (
    .clk(clk), .rst(rst), .addr_i(addr), .pin15_i(p15i), .wide_i(wide),
    .ce_n_i(ce_n), .oe_i(oe), .data_o(dat[2]), .drive_o(drv[2]),
    .pin15_o(p15o[2]), .pin15_oe_o(p15oe[2]));

  // R11 fill rule
  function automatic logic [15:0] ref_word(logic [AW-1:0] a);
    logic [31:0] i;
    logic [31:0] acc;
    i   = 32'(a) % (32'd1 << DLOG);
    acc = i * 32'd40503 + 32'(SEED);
    return acc[15:0];
  endfunction

  function automatic bit ref_en(int opt, logic c, logic o);
    if (c) return 1'b0;
    if (opt == 0) return !o;
    if (opt == 1) return o;
    return 1'b1;
  endfunction

  // {pin15_oe, pin15, drive[14:0], data[14:0]}
  function automatic logic [31:0] ref_out(int opt, bit in_rst, logic [AW-1:0] a,
                                          logic p, logic w, logic c, logic o);
    logic [15:0] wd;
    logic [7:0]  b;
    if (in_rst || !ref_en(opt, c, o)) return 32'h0;
    wd = ref_word(a);
    if (w) return {1'b1, wd[15], 15'h7FFF, wd[14:0]};
    b = p ? wd[15:8] : wd[7:0];
    return {1'b0, 1'b0, 15'h00FF, 7'h00, b};
  endfunction

  function automatic string ref_tag(int opt, bit in_rst, logic w, logic c, logic o);
    if (in_rst) return "R9";
    if (c) return "R4";
    if (!ref_en(opt, c, o)) return (opt == 0) ? "R5" : "R6";
    if (opt == 2) return w ? "R7 R1" : "R7 R2 R3 R8";
    return w ? "R1" : "R2 R3 R8";
  endfunction

  task automatic check_vals(string pre, bit in_rst, logic [AW-1:0] a,
                            logic p, logic w, logic c, logic o);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] exp_v;
      logic [31:0] act_v;
      exp_v = ref_out(k, in_rst, a, p, w, c, o);
      act_v = {p15oe[k], p15o[k], drv[k], dat[k]};
      tests++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s %s opt=%0d addr=%h lsb=%b wide=%b ce_n=%b oe=%b actual=%h expected=%h",
                 pre, ref_tag(k, in_rst, w, c, o), k, a, p, w, c, o, act_v, exp_v);
      end
    end
  endtask

  task automatic apply(string pre, logic [AW-1:0] a, logic p, logic w, logic c, logic o);
    @(negedge clk);
    addr = a; p15i = p; wide = w; ce_n = c; oe = o;
    @(negedge clk);
    @(negedge clk);
    check_vals(pre, 1'b0, a, p, w, c, o);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    // R9: held in reset with enabled word-mode inputs
    addr = 20'd5; wide = 1'b1; ce_n = 1'b0; oe = 1'b0;
    repeat (3) @(negedge clk);
    check_vals("reset", 1'b1, addr, p15i, wide, ce_n, oe);
    rst = 1'b0;
    @(negedge clk);
    check_vals("first-edge", 1'b1, addr, p15i, wide, ce_n, oe);
    @(negedge clk);
    check_vals("after-reset", 1'b0, addr, p15i, wide, ce_n, oe);

    // R1 word reads, pin15_i ignored
    apply("R1", 20'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R1", 20'd255, 1'b1, 1'b1, 1'b0, 1'b1);
    apply("R1", 20'd77, 1'b1, 1'b1, 1'b0, 1'b0);
    // R11 wrap
    apply("R11", 20'd256, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R11", 20'hFFFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    apply("R11", 20'hFFF00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2 byte low/high
    apply("R2", 20'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R2", 20'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R2", 20'd200, 1'b1, 1'b0, 1'b0, 1'b1);
    // R4 standby both oe values, both modes
    apply("R4", 20'd9, 1'b0, 1'b1, 1'b1, 1'b0);
    apply("R4", 20'd9, 1'b1, 1'b0, 1'b1, 1'b1);
    // R5 R6 R7 oe polarity
    apply("R5 R6 R7", 20'd33, 1'b0, 1'b1, 1'b0, 1'b1);
    apply("R5 R6 R7", 20'd33, 1'b1, 1'b0, 1'b0, 1'b0);

    // R10: one edge after a change the old result is still present
    apply("R10", 20'd10, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    addr = 20'd11; p15i = 1'b1; wide = 1'b0; ce_n = 1'b0; oe = 1'b0;
    @(negedge clk);
    check_vals("R10 hold", 1'b0, 20'd10, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_vals("R10 new", 1'b0, 20'd11, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] ra;
      logic rp, rw, rc, ro;
      ra = AW'($urandom);
      rp = 1'($urandom);
      rw = 1'($urandom);
      rc = (($urandom % 4) == 0);
      ro = 1'($urandom);
      apply("rand", ra, rp, rw, rc, ro);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule